// File: doc/BRIEF.md
# Register-Routed Stream Crossbar

The crossbar links `NUM_IN` stream inputs to `NUM_OUT` stream outputs, with both counts running from 1 to 16. A build-time mode parameter selects how traffic is steered. In register mode, each output reads from the input named in its own routing word. In destination mode, a single input is steered by the destination field that travels with each beat, and the routing words have no effect.

In register mode, software writes routing words into a staging copy. Writing the update bit of the control word then commits every staged word in one go. Each output loads the committed word only at a packet boundary, so a packet is never split between two sources. An output can be switched off with its disable bit. One input can feed several outputs. A beat on such an input moves only when every output fed by it is ready.

The datapath is combinational: there is no register stage and no buffer between an input and an output.

Top module: `sw_xbar`

## Requirements
- R1: After reset, every output holds valid low. Every routing word reads `0x8000_0000`, and the control word reads 0.
- R2: The routing word for output `i` sits at byte address `0x40 + 4*i`. Bit 31 is the disable flag and bits 3:0 are the input index. A read returns only those bits, with every other bit 0.
- R3: Writing a routing word does not change forwarding until the update bit is written.
- R4: Writing 1 to bit 1 of the control word at address `0x00` commits all staged routing words at once. An idle output starts using its new route after the second rising edge that follows the write.
- R5: An output whose active word has the disable bit set, or an index at or above `NUM_IN`, keeps valid low.
- R6: An enabled output carries the data, last flag and destination of its selected input. Several outputs may select the same input. An output's valid is high when its input is valid and that input's ready is high.
- R7: An input's ready is the AND of the ready signals of all enabled outputs that select it. It is low when no enabled output selects it.
- R8: While an output is inside a packet, a committed change for that output is held. It is applied on the edge where that output completes a beat with the last flag set.
- R9: Bit 1 of the control word reads 1 from the edge of the commit write until every output has applied the commit, and 0 after that.
- R10: In destination mode, input 0 drives output `i` valid exactly when its destination field equals `i`. Its ready follows that output's ready. A beat whose destination is at or above `NUM_OUT` is accepted and dropped.
- R11: In destination mode, writes to the routing and control words have no effect on forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address (write and read) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| s_tvalid_i | input | NUM_IN | Input valid per port |
| s_tready_o | output | NUM_IN | Input ready per port |
| s_tdata_i | input | NUM_IN*DATA_W | Input data, port j at bits `j*DATA_W` |
| s_tlast_i | input | NUM_IN | Input end-of-packet flag |
| s_tdest_i | input | NUM_IN*DEST_W | Input destination field |
| m_tvalid_o | output | NUM_OUT | Output valid per port |
| m_tready_i | input | NUM_OUT | Output ready per port |
| m_tdata_o | output | NUM_OUT*DATA_W | Output data |
| m_tlast_o | output | NUM_OUT | Output end-of-packet flag |
| m_tdest_o | output | NUM_OUT*DEST_W | Output destination field |

## Verification
Two events can fall in the same cycle: a commit, and the last beat of a packet on an output that is mid-packet. The bench starts an open-ended packet on one output and commits a new source while beats keep flowing. It then confirms that the old source still drives the output and that the update bit still reads 1. Next it raises the last flag for one beat. It then checks that the new source takes over on exactly that edge and that the update bit drops.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int MAX_PORTS = 16;
  localparam int IDX_W     = 4;

  typedef struct packed {
    logic             dis;
    logic [IDX_W-1:0] idx;
  } sel_t;

  localparam sel_t SEL_RST = '{dis: 1'b1, idx: '0};
endpackage

// File: rtl/sw_regs.sv
module sw_regs
  import sw_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  input  logic                      pend_any_i,
  output sel_t [NUM_OUT-1:0]        staged_o,
  output logic                      commit_o
);
  logic             is_ctrl, is_sel;
  logic [IDX_W-1:0] slot;
  logic             unused_bits;

  assign is_ctrl  = (addr_i == '0);
  assign is_sel   = (addr_i[ADDR_W-1:6] == (ADDR_W-6)'(1)) && (addr_i[1:0] == 2'b00);
  assign slot     = addr_i[5:2];
  assign commit_o = wr_i & is_ctrl & wdata_i[1];
  assign unused_bits = ^{wdata_i[30:4], wdata_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_OUT; i++) staged_o[i] <= SEL_RST;
    end else begin
      for (int i = 0; i < NUM_OUT; i++)
        if (wr_i && is_sel && slot == IDX_W'(i))
          staged_o[i] <= '{dis: wdata_i[31], idx: wdata_i[IDX_W-1:0]};
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_ctrl) rdata_o[1] = pend_any_i;
    for (int i = 0; i < NUM_OUT; i++)
      if (is_sel && slot == IDX_W'(i))
        rdata_o = {staged_o[i].dis, 27'b0, staged_o[i].idx};
  end
endmodule

// File: rtl/sw_route_ctl.sv
module sw_route_ctl
  import sw_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  sel_t             staged_i,
  input  logic             hs_i,
  input  logic             last_i,
  output logic             act_en_o,
  output logic [IDX_W-1:0] act_idx_o,
  output logic             pend_o,
  output logic             busy_o
);
  sel_t act_q, nxt_q;
  logic apply;

  // safe point: idle with no beat now, or the beat now closes the packet
  assign apply = pend_o & (hs_i ? last_i : ~busy_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= SEL_RST;
      nxt_q  <= SEL_RST;
      pend_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      if (commit_i) begin
        pend_o <= 1'b1;
        nxt_q  <= staged_i;
      end else if (apply) begin
        pend_o <= 1'b0;
      end
      if (apply) act_q <= nxt_q;
      if (hs_i) busy_o <= ~last_i;
    end
  end

  assign act_en_o  = ~act_q.dis && ({1'b0, act_q.idx} < 5'(NUM_IN));
  assign act_idx_o = act_q.idx;
endmodule

// File: rtl/sw_xbar.sv
module sw_xbar
  import sw_pkg::*;
#(
  parameter int NUM_IN     = 4,
  parameter int NUM_OUT    = 4,
  parameter int DATA_W     = 32,
  parameter int DEST_W     = 4,
  parameter int ADDR_W     = 8,
  parameter int ROUTE_MODE = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_wr_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  input  logic [NUM_IN-1:0]         s_tvalid_i,
  output logic [NUM_IN-1:0]         s_tready_o,
  input  logic [NUM_IN*DATA_W-1:0]  s_tdata_i,
  input  logic [NUM_IN-1:0]         s_tlast_i,
  input  logic [NUM_IN*DEST_W-1:0]  s_tdest_i,
  output logic [NUM_OUT-1:0]        m_tvalid_o,
  input  logic [NUM_OUT-1:0]        m_tready_i,
  output logic [NUM_OUT*DATA_W-1:0] m_tdata_o,
  output logic [NUM_OUT-1:0]        m_tlast_o,
  output logic [NUM_OUT*DEST_W-1:0] m_tdest_o
);
  localparam int MAXP = MAX_PORTS;

  sel_t [NUM_OUT-1:0]            staged;
  logic                          commit;
  logic [NUM_OUT-1:0]            pend, busy, act_en, hs;
  logic [NUM_OUT-1:0][IDX_W-1:0] act_idx;

  // inputs padded to the full index range so a 4-bit select never runs off the end
  logic [MAXP-1:0]   sv_ext, sl_ext;
  logic [DATA_W-1:0] sd_ext [MAXP];
  logic [DEST_W-1:0] st_ext [MAXP];

  for (genvar j = 0; j < MAXP; j++) begin : g_ext
    if (j < NUM_IN) begin : g_real
      assign sv_ext[j] = s_tvalid_i[j];
      assign sl_ext[j] = s_tlast_i[j];
      assign sd_ext[j] = s_tdata_i[j*DATA_W +: DATA_W];
      assign st_ext[j] = s_tdest_i[j*DEST_W +: DEST_W];
    end else begin : g_pad
      assign sv_ext[j] = 1'b0;
      assign sl_ext[j] = 1'b0;
      assign sd_ext[j] = '0;
      assign st_ext[j] = '0;
    end
  end

  sw_regs #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .pend_any_i (|pend),
    .staged_o   (staged),
    .commit_o   (commit)
  );

  assign hs = m_tvalid_o & m_tready_i;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_rc
    sw_route_ctl #(.NUM_IN(NUM_IN)) u_rc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .commit_i  (commit),
      .staged_i  (staged[i]),
      .hs_i      (hs[i]),
      .last_i    (m_tlast_o[i]),
      .act_en_o  (act_en[i]),
      .act_idx_o (act_idx[i]),
      .pend_o    (pend[i]),
      .busy_o    (busy[i])
    );
  end

  if (ROUTE_MODE == 1) begin : g_reg_mode
    logic [MAXP-1:0] sr_ext;

    always_comb begin
      logic hit, rdy;
      for (int j = 0; j < MAXP; j++) begin
        hit = 1'b0;
        rdy = 1'b1;
        for (int i = 0; i < NUM_OUT; i++)
          if (act_en[i] && act_idx[i] == IDX_W'(j)) begin
            hit = 1'b1;
            rdy = rdy & m_tready_i[i];
          end
        sr_ext[j] = hit & rdy;
      end
    end

    assign s_tready_o = sr_ext[NUM_IN-1:0];

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      assign m_tvalid_o[i] = act_en[i] & sv_ext[act_idx[i]] & sr_ext[act_idx[i]];
      assign m_tdata_o[i*DATA_W +: DATA_W] = sd_ext[act_idx[i]];
      assign m_tlast_o[i] = sl_ext[act_idx[i]];
      assign m_tdest_o[i*DEST_W +: DEST_W] = st_ext[act_idx[i]];
    end
  end else begin : g_dest_mode
    logic [DEST_W-1:0] dest;
    logic              rdy0;

    assign dest = st_ext[0];

    always_comb begin
      rdy0 = 1'b1;
      for (int i = 0; i < NUM_OUT; i++)
        if (dest == DEST_W'(i)) rdy0 = m_tready_i[i];
    end

    assign s_tready_o = NUM_IN'(rdy0);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      assign m_tvalid_o[i] = sv_ext[0] && (dest == DEST_W'(i));
      assign m_tdata_o[i*DATA_W +: DATA_W] = sd_ext[0];
      assign m_tlast_o[i] = sl_ext[0];
      assign m_tdest_o[i*DEST_W +: DEST_W] = dest;
    end
  end
endmodule

// File: rtl/sw_xbar_chk.sv
module sw_xbar_chk
  import sw_pkg::*;
#(
  parameter int NUM_IN     = 4,
  parameter int NUM_OUT    = 4,
  parameter int ROUTE_MODE = 1
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_OUT-1:0]            m_tvalid_o,
  input logic [NUM_OUT-1:0]            m_tready_i,
  input logic [NUM_OUT-1:0]            m_tlast_o,
  input logic [NUM_IN-1:0]             s_tready_o,
  input logic [NUM_OUT-1:0]            act_en,
  input logic [NUM_OUT-1:0][IDX_W-1:0] act_idx,
  input logic [NUM_OUT-1:0]            pend,
  input logic [NUM_OUT-1:0]            busy,
  input logic                          commit
);
  logic [MAX_PORTS-1:0] s_rdy16;
  assign s_rdy16 = MAX_PORTS'(s_tready_o);

  assert_quiet_at_reset_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (m_tvalid_o == '0));

  if (ROUTE_MODE == 1) begin : g_chk
    assert_commit_marks_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit |=> (pend == '1));

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_o
      assert_disabled_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_tvalid_o[i] |-> act_en[i]);

      assert_group_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_tvalid_o[i] |-> s_rdy16[act_idx[i]]);

      assert_hold_in_packet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy[i] && !(m_tvalid_o[i] && m_tready_i[i] && m_tlast_o[i]))
        |=> ($stable(act_idx[i]) && $stable(act_en[i])));

      assert_no_change_without_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pend[i] && !commit) |=> ($stable(act_idx[i]) && $stable(act_en[i])));
    end
  end
endmodule

bind sw_xbar sw_xbar_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ROUTE_MODE(ROUTE_MODE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .m_tvalid_o (m_tvalid_o),
  .m_tready_i (m_tready_i),
  .m_tlast_o  (m_tlast_o),
  .s_tready_o (s_tready_o),
  .act_en     (act_en),
  .act_idx    (act_idx),
  .pend       (pend),
  .busy       (busy),
  .commit     (commit)
);

// File: tb/sw_xbar_tb.sv
module sw_xbar_tb;
  localparam int NI = 3;
  localparam int NO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata, td_rdata;

  logic [NI-1:0]   sv = '0, sl = '1;
  logic [NI*8-1:0] sd = '0;
  logic [NI*4-1:0] sdest = '0;
  wire  [NI-1:0]   sr;
  wire  [NO-1:0]   mv, ml;
  logic [NO-1:0]   mr = '0;
  wire  [NO*8-1:0] md;
  wire  [NO*4-1:0] mdest;

  logic       tv = 1'b0, tl = 1'b1;
  logic [7:0] tdd = '0;
  logic [3:0] tdst = '0;
  wire        tr;
  wire [NO-1:0]   tmv, tml;
  logic [NO-1:0]  tmr = '0;
  wire [NO*8-1:0] tmd;
  wire [NO*4-1:0] tmdest;

  sw_xbar #(.NUM_IN(NI), .NUM_OUT(NO), .DATA_W(8), .DEST_W(4), .ADDR_W(8), .ROUTE_MODE(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .s_tvalid_i(sv), .s_tready_o(sr), .s_tdata_i(sd), .s_tlast_i(sl),
    .s_tdest_i(sdest), .m_tvalid_o(mv), .m_tready_i(mr), .m_tdata_o(md), .m_tlast_o(ml),
    .m_tdest_o(mdest));

  sw_xbar #(.NUM_IN(1), .NUM_OUT(NO), .DATA_W(8), .DEST_W(4), .ADDR_W(8), .ROUTE_MODE(0)) u_dut_td (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(td_rdata), .s_tvalid_i(tv), .s_tready_o(tr), .s_tdata_i(tdd), .s_tlast_i(tl),
    .s_tdest_i(tdst), .m_tvalid_o(tmv), .m_tready_i(tmr), .m_tdata_o(tmd), .m_tlast_o(tml),
    .m_tdest_o(tmdest));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] stg [NO];
  logic [31:0] act [NO];

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_sel(input int i, input logic [31:0] d);
    wr_reg(8'(8'h40 + 4*i), d);
    stg[i] = d;
  endtask

  task automatic do_commit;
    wr_reg(8'h00, 32'h2);
    @(negedge clk);
    for (int i = 0; i < NO; i++) act[i] = stg[i];
  endtask

  function automatic logic [31:0] code_of(input int c);
    case (c)
      0, 1, 2: return 32'(c);
      3:       return 32'h3;
      4:       return 32'h0000_000F;
      default: return 32'h8000_0001;
    endcase
  endfunction

  task automatic set_data(input int p);
    for (int j = 0; j < NI; j++) begin
      sd[j*8 +: 8]    = 8'(p*3 + j*40 + 1);
      sdest[j*4 +: 4] = 4'(j + 3);
    end
  endtask

  // drive one input pattern and compare the combinational outputs
  task automatic check_pattern(input logic [NO-1:0] tr_pat, input logic [NI-1:0] v_pat, input int p);
    logic [NI-1:0] esr;
    logic [NO-1:0] emv;
    logic          hit, rdy, en;
    int            idx;
    @(negedge clk);
    mr = tr_pat; sv = v_pat; sl = '1;
    set_data(p);
    #1;
    for (int j = 0; j < NI; j++) begin
      hit = 0; rdy = 1;
      for (int i = 0; i < NO; i++)
        if (!act[i][31] && act[i][3:0] < 3 && int'(act[i][3:0]) == j) begin
          hit = 1; rdy = rdy & tr_pat[i];
        end
      esr[j] = hit & rdy;
    end
    for (int i = 0; i < NO; i++) begin
      en  = !act[i][31] && act[i][3:0] < 3;
      idx = int'(act[i][3:0]);
      emv[i] = en && v_pat[idx] && esr[idx];
    end
    check("R7 input ready", 64'(sr), 64'(esr));
    check("R5 R6 output valid", 64'(mv), 64'(emv));
    for (int i = 0; i < NO; i++)
      if (emv[i]) begin
        idx = int'(act[i][3:0]);
        check("R6 forwarded beat", {51'b0, ml[i], mdest[i*4 +: 4], md[i*8 +: 8]},
              {51'b0, 1'b1, 4'(idx + 3), sd[idx*8 +: 8]});
      end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NO; i++) begin stg[i] = 32'h8000_0000; act[i] = 32'h8000_0000; end
    repeat (3) @(negedge clk);
    check("R1 valid low in reset", 64'(mv), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    sv = '1; mr = '1;
    #1;
    check("R1 valid low after reset", 64'(mv), 64'h0);
    for (int i = 0; i < NO; i++) begin
      rd_reg(8'(8'h40 + 4*i), d);
      check("R1 routing word reset", 64'(d), 64'h8000_0000);
    end
    rd_reg(8'h00, d);
    check("R1 control reset", 64'(d), 64'h0);

    // R2 field layout
    set_sel(0, 32'h0000_0002);
    rd_reg(8'h40, d);
    check("R2 readback index", 64'(d), 64'h2);
    set_sel(2, 32'hFFFF_FFF1);
    rd_reg(8'h48, d);
    check("R2 readback masked", 64'(d), 64'h8000_0001);

    // R3 staged only
    set_sel(0, 32'h1); set_sel(1, 32'h1); set_sel(2, 32'hF); set_sel(3, 32'h8000_0000);
    repeat (2) begin
      @(negedge clk); #1;
      check("R3 no effect before commit", 64'(mv), 64'h0);
    end

    // R4 R9 commit timing
    wr_reg(8'h00, 32'h2);
    rd_reg(8'h00, d);
    check("R9 update pending", 64'(d), 64'h2);
    #1; check("R4 not yet applied", 64'(mv), 64'h0);
    @(negedge clk);
    for (int i = 0; i < NO; i++) act[i] = stg[i];
    rd_reg(8'h00, d);
    check("R9 update cleared", 64'(d), 64'h0);
    check("R4 applied together", 64'(mv), 64'h3);

    // R5 R6 R7 sweep over routings and handshake patterns
    for (int cfg = 0; cfg < 24; cfg++) begin
      for (int i = 0; i < NO; i++) set_sel(i, code_of((cfg*7 + i*5) % 6));
      do_commit();
      rd_reg(8'h00, d);
      check("R4 R9 commit done", 64'(d), 64'h0);
      for (int p = 0; p < 128; p++)
        check_pattern(4'(p), 3'(p >> 4), p + cfg);
    end

    // R8 packet boundary
    @(negedge clk); sv = '0;
    set_sel(0, 32'h0);
    for (int i = 1; i < NO; i++) set_sel(i, 32'h8000_0000);
    do_commit();
    @(negedge clk);
    sl = '0; sv = 3'b011; mr = '1; set_data(5);
    repeat (2) @(negedge clk);
    set_sel(0, 32'h1);
    wr_reg(8'h00, 32'h2);
    repeat (2) @(negedge clk);
    #1;
    check("R8 old source held", {55'b0, mv[0], md[7:0]}, {55'b0, 1'b1, sd[7:0]});
    rd_reg(8'h00, d);
    check("R8 R9 still pending", 64'(d), 64'h2);
    @(negedge clk); sl = 3'b001;
    @(negedge clk); sl = 3'b000;
    #1;
    check("R8 switched at last", {55'b0, mv[0], md[7:0]}, {55'b0, 1'b1, sd[15:8]});
    rd_reg(8'h00, d);
    check("R8 R9 cleared", 64'(d), 64'h0);
    @(negedge clk); sl = '1; sv = '0;

    // R10 R11 destination mode (its register bus saw every write above)
    for (int ds = 0; ds < 16; ds++)
      for (int rp = 0; rp < 16; rp++)
        for (int v = 0; v < 2; v++) begin
          tdst = 4'(ds); tmr = 4'(rp); tv = v[0]; tdd = 8'(ds*16 + rp);
          #1;
          check("R10 R11 dest valid", 64'(tmv), (v == 1 && ds < NO) ? 64'(1 << ds) : 64'h0);
          check("R10 dest ready", 64'(tr), (ds < NO) ? 64'((rp >> ds) & 1) : 64'h1);
          if (v == 1 && ds < NO)
            check("R10 dest data", {52'b0, tmdest[ds*4 +: 4], tmd[ds*8 +: 8]},
                  {52'b0, 4'(ds), 8'(ds*16 + rp)});
        end

    finish_run();
  end
endmodule